// File: doc/BRIEF.md
# Capability Page Tag and Generation Checker

This block sits beside the load/store unit and judges every memory access that moves a capability through a translated page. It decides what happens to the capability's validity tag, whether a load or store page fault is raised, and whether the page-table entry has to be changed. It bases that decision on the page's capability-write permit bit, the page's revocation generation bit, the current privilege level and the generation bits held in the status words.

A page without the write permit returns loaded capabilities with the tag stripped. A page with the permit compares its generation bit against the generation bit of the current privilege level. On a mismatch the block faults, either always or only when the loaded tag is set. A tagged capability stored to a page without the permit either faults or produces a one-shot request to rewrite the entry with the permit set. While that request is waiting for acknowledgement, the access stalls.

Each accepted request produces exactly one registered response. For a direct decision the response comes one cycle after acceptance. When an entry rewrite is needed, the response comes one cycle after the rewrite is acknowledged.

Top module: `cap_page_guard`

## Requirements
- R1: A capability load or atomic (req_kind 2'b01 or 2'b11) on a translated page with pte_cw=0 returns rsp_tag=0 with no load fault, whatever the privilege level.
- R2: With pte_cw=1 the page generation bit is compared to the status word bit at position XLEN-2 in supervisor mode (priv_user=0) or at position XLEN-3 in user mode (priv_user=1). On a match, mem_tag passes to rsp_tag without fault.
- R3: On a generation mismatch, cfg_tag_sensitive=0 raises rsp_ld_fault unconditionally and cfg_tag_sensitive=1 raises it only when mem_tag=1. Whenever any fault is reported, rsp_tag is 0.
- R4: With virt_on=1 the generation bit is taken from vsts_word instead of sts_word.
- R5: A capability store or atomic (req_kind 2'b10 or 2'b11) with an effective tag of 1 to a page with pte_cw=0 and cfg_hw_dirty=0 raises rsp_st_fault.
- R6: The same store with cfg_hw_dirty=1 raises upd_valid one cycle after acceptance, with upd_cw=1 and upd_crg equal to the selected generation bit. upd_valid and upd_crg are held and req_ready is 0 until upd_ready. The fault-free response follows one cycle after the handshake.
- R7: The effective store tag is wr_tag AND NOT wr_tag_clr. A cleared tag causes neither fault nor update.
- R8: With req_is_cap=0, xlate_on=0 or req_kind=2'b00, no fault and no update arise, and for loads mem_tag passes unchanged.
- R9: When perm_fault_ld or perm_fault_st is set, those faults are reported as given, with rsp_tag=0 and no capability fault or update.
- R10: An access that needs no update gets rsp_valid exactly one cycle after acceptance. For req_kind 2'b00 or 2'b10, rsp_tag is 0.
- R11: An atomic applies both the load check and the store check in the same access.
- R12: During and right after reset, rsp_valid=0, upd_valid=0 and req_ready=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Block can accept a request |
| req_kind | input | 2 | 00 none, 01 load, 10 store, 11 atomic |
| req_is_cap | input | 1 | Access moves a capability |
| xlate_on | input | 1 | Address translation active |
| priv_user | input | 1 | Current privilege: 1 user, 0 supervisor |
| virt_on | input | 1 | Virtualization active |
| sts_word | input | XLEN | Supervisor status word |
| vsts_word | input | XLEN | Virtual-supervisor status word |
| pte_cw | input | 1 | Page capability-write permit |
| pte_crg | input | 1 | Page revocation generation bit |
| mem_tag | input | 1 | Tag of capability read from memory |
| wr_tag | input | 1 | Tag of capability being written |
| wr_tag_clr | input | 1 | Earlier stage has cleared the written tag |
| perm_fault_ld | input | 1 | Ordinary load permission fault |
| perm_fault_st | input | 1 | Ordinary store permission fault |
| cfg_tag_sensitive | input | 1 | Mismatch faults only when tag set |
| cfg_hw_dirty | input | 1 | Hardware entry update instead of store fault |
| rsp_valid | output | 1 | Response valid |
| rsp_tag | output | 1 | Resulting load tag |
| rsp_ld_fault | output | 1 | Load page fault |
| rsp_st_fault | output | 1 | Store page fault |
| upd_valid | output | 1 | Entry update request |
| upd_ready | input | 1 | Entry update accepted |
| upd_cw | output | 1 | New write-permit value |
| upd_crg | output | 1 | New generation value |

## Verification
The assertions check the following on every cycle: the update request is held steady until acknowledged and stalls intake; stripped tags appear on permit-less loads; any fault zeroes the tag; ordinary permission faults win over capability faults; and bypassed accesses stay fault-free. Only the bench scenarios can show the behaviour that depends on the values involved. That covers picking the generation bit by privilege level and by virtualization from fixed bit positions, the two mismatch schemes, the masking of the store tag by earlier clearing, and the combined outcome of an atomic.

// File: rtl/cap_guard_pkg.sv
package cap_guard_pkg;

  localparam logic [1:0] KIND_NONE  = 2'b00;
  localparam logic [1:0] KIND_LOAD  = 2'b01;
  localparam logic [1:0] KIND_STORE = 2'b10;
  localparam logic [1:0] KIND_AMO   = 2'b11;

  typedef enum logic { ST_IDLE = 1'b0, ST_WAIT_UPD = 1'b1 } guard_state_e;

  typedef struct packed {
    logic tag;
    logic ld_fault;
    logic st_fault;
    logic need_upd;
    logic upd_crg;
  } guard_verdict_t;

  function automatic logic kind_reads(input logic [1:0] k);
    return (k == KIND_LOAD) || (k == KIND_AMO);
  endfunction

  function automatic logic kind_writes(input logic [1:0] k);
    return (k == KIND_STORE) || (k == KIND_AMO);
  endfunction

endpackage

// File: rtl/cap_gen_select.sv
module cap_gen_select #(
  parameter int XLEN     = 64,
  parameter int UGEN_POS = 61,
  parameter int SGEN_POS = 62
) (
  input  logic [XLEN-1:0] sts_word,
  input  logic [XLEN-1:0] vsts_word,
  input  logic            virt_on,
  input  logic            priv_user,
  output logic            gen_bit
);

  logic [XLEN-1:0] word_sel;
  logic            unused_rest;

  always_comb begin
    word_sel = virt_on ? vsts_word : sts_word;
    gen_bit  = priv_user ? word_sel[UGEN_POS] : word_sel[SGEN_POS];
  end

  assign unused_rest = ^word_sel;

endmodule

// File: rtl/cap_load_eval.sv
module cap_load_eval (
  input  logic active,
  input  logic reads,
  input  logic pte_cw,
  input  logic pte_crg,
  input  logic gen_bit,
  input  logic mem_tag,
  input  logic cfg_tag_sensitive,
  output logic tag_out,
  output logic fault
);

  logic gen_mismatch;

  always_comb begin
    gen_mismatch = pte_crg ^ gen_bit;
    tag_out      = 1'b0;
    fault        = 1'b0;
    if (reads) begin
      if (!active) begin
        tag_out = mem_tag;
      end else if (!pte_cw) begin
        tag_out = 1'b0;
      end else if (gen_mismatch) begin
        fault   = cfg_tag_sensitive ? mem_tag : 1'b1;
        tag_out = fault ? 1'b0 : mem_tag;
      end else begin
        tag_out = mem_tag;
      end
    end
  end

endmodule

// File: rtl/cap_store_eval.sv
module cap_store_eval (
  input  logic active,
  input  logic writes,
  input  logic pte_cw,
  input  logic gen_bit,
  input  logic wr_tag,
  input  logic wr_tag_clr,
  input  logic cfg_hw_dirty,
  output logic fault,
  output logic need_upd,
  output logic new_crg
);

  logic eff_tag;
  logic hit;

  always_comb begin
    eff_tag  = wr_tag & ~wr_tag_clr;
    hit      = active & writes & ~pte_cw & eff_tag;
    fault    = hit & ~cfg_hw_dirty;
    need_upd = hit & cfg_hw_dirty;
    new_crg  = gen_bit;
  end

endmodule

// File: rtl/cap_resp_seq.sv
module cap_resp_seq
  import cap_guard_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  guard_verdict_t verdict,
  input  logic           upd_ready,
  output logic           req_ready,
  output logic           rsp_valid,
  output logic           rsp_tag,
  output logic           rsp_ld_fault,
  output logic           rsp_st_fault,
  output logic           upd_valid,
  output logic           upd_crg
);

  guard_state_e   state_q, state_d;
  logic           rsp_valid_q, rsp_valid_d;
  logic [2:0]     rsp_q, rsp_d;
  logic           upd_valid_q, upd_valid_d;
  logic           upd_crg_q, upd_crg_d;
  logic [2:0]     pend_q, pend_d;
  logic           pend_en;
  logic           accept;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid & req_ready;

  always_comb begin
    state_d     = state_q;
    rsp_valid_d = 1'b0;
    rsp_d       = rsp_q;
    upd_valid_d = upd_valid_q;
    upd_crg_d   = upd_crg_q;
    pend_d      = pend_q;
    pend_en     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (verdict.need_upd) begin
            state_d     = ST_WAIT_UPD;
            upd_valid_d = 1'b1;
            upd_crg_d   = verdict.upd_crg;
            pend_d      = {verdict.tag, verdict.ld_fault, verdict.st_fault};
            pend_en     = 1'b1;
          end else begin
            rsp_valid_d = 1'b1;
            rsp_d       = {verdict.tag, verdict.ld_fault, verdict.st_fault};
          end
        end
      end
      ST_WAIT_UPD: begin
        if (upd_ready) begin
          state_d     = ST_IDLE;
          upd_valid_d = 1'b0;
          rsp_valid_d = 1'b1;
          rsp_d       = pend_q;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      rsp_valid_q <= 1'b0;
      rsp_q       <= '0;
      upd_valid_q <= 1'b0;
      upd_crg_q   <= 1'b0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rsp_valid_d;
      rsp_q       <= rsp_d;
      upd_valid_q <= upd_valid_d;
      upd_crg_q   <= upd_crg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  assign rsp_valid    = rsp_valid_q;
  assign rsp_tag      = rsp_q[2];
  assign rsp_ld_fault = rsp_q[1];
  assign rsp_st_fault = rsp_q[0];
  assign upd_valid    = upd_valid_q;
  assign upd_crg      = upd_crg_q;

endmodule

// File: rtl/cap_page_guard.sv
module cap_page_guard
  import cap_guard_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [1:0]      req_kind,
  input  logic            req_is_cap,
  input  logic            xlate_on,
  input  logic            priv_user,
  input  logic            virt_on,
  input  logic [XLEN-1:0] sts_word,
  input  logic [XLEN-1:0] vsts_word,
  input  logic            pte_cw,
  input  logic            pte_crg,
  input  logic            mem_tag,
  input  logic            wr_tag,
  input  logic            wr_tag_clr,
  input  logic            perm_fault_ld,
  input  logic            perm_fault_st,
  input  logic            cfg_tag_sensitive,
  input  logic            cfg_hw_dirty,
  output logic            rsp_valid,
  output logic            rsp_tag,
  output logic            rsp_ld_fault,
  output logic            rsp_st_fault,
  output logic            upd_valid,
  input  logic            upd_ready,
  output logic            upd_cw,
  output logic            upd_crg
);

  localparam int UGEN_POS = XLEN - 3;
  localparam int SGEN_POS = XLEN - 2;

  logic           active;
  logic           reads;
  logic           writes;
  logic           gen_bit;
  logic           ld_tag;
  logic           ld_fault_cap;
  logic           st_fault_cap;
  logic           st_need_upd;
  logic           st_new_crg;
  logic           perm_any;
  guard_verdict_t verdict;

  assign active = req_is_cap & xlate_on;
  assign reads  = kind_reads(req_kind);
  assign writes = kind_writes(req_kind);

  cap_gen_select #(
    .XLEN     (XLEN),
    .UGEN_POS (UGEN_POS),
    .SGEN_POS (SGEN_POS)
  ) u_gen (
    .sts_word  (sts_word),
    .vsts_word (vsts_word),
    .virt_on   (virt_on),
    .priv_user (priv_user),
    .gen_bit   (gen_bit)
  );

  cap_load_eval u_ld (
    .active            (active),
    .reads             (reads),
    .pte_cw            (pte_cw),
    .pte_crg           (pte_crg),
    .gen_bit           (gen_bit),
    .mem_tag           (mem_tag),
    .cfg_tag_sensitive (cfg_tag_sensitive),
    .tag_out           (ld_tag),
    .fault             (ld_fault_cap)
  );

  cap_store_eval u_st (
    .active       (active),
    .writes       (writes),
    .pte_cw       (pte_cw),
    .gen_bit      (gen_bit),
    .wr_tag       (wr_tag),
    .wr_tag_clr   (wr_tag_clr),
    .cfg_hw_dirty (cfg_hw_dirty),
    .fault        (st_fault_cap),
    .need_upd     (st_need_upd),
    .new_crg      (st_new_crg)
  );

  always_comb begin
    perm_any         = perm_fault_ld | perm_fault_st;
    verdict.ld_fault = perm_any ? perm_fault_ld : ld_fault_cap;
    verdict.st_fault = perm_any ? perm_fault_st : st_fault_cap;
    verdict.need_upd = ~perm_any & st_need_upd;
    verdict.upd_crg  = st_new_crg;
    verdict.tag      = (verdict.ld_fault | verdict.st_fault) ? 1'b0 : ld_tag;
  end

  cap_resp_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .verdict      (verdict),
    .upd_ready    (upd_ready),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .rsp_tag      (rsp_tag),
    .rsp_ld_fault (rsp_ld_fault),
    .rsp_st_fault (rsp_st_fault),
    .upd_valid    (upd_valid),
    .upd_crg      (upd_crg)
  );

  assign upd_cw = upd_valid;

endmodule

// File: rtl/cap_page_guard_chk.sv
module cap_page_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [1:0] req_kind,
  input logic       req_is_cap,
  input logic       xlate_on,
  input logic       pte_cw,
  input logic       mem_tag,
  input logic       perm_fault_ld,
  input logic       perm_fault_st,
  input logic       rsp_valid,
  input logic       rsp_tag,
  input logic       rsp_ld_fault,
  input logic       rsp_st_fault,
  input logic       upd_valid,
  input logic       upd_ready,
  input logic       upd_cw,
  input logic       upd_crg
);

  logic acc;
  logic no_perm;
  assign acc     = req_valid & req_ready;
  assign no_perm = ~perm_fault_ld & ~perm_fault_st;

  assert_cw0_strip_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_is_cap && xlate_on && !pte_cw && req_kind == 2'b01 && no_perm
    |=> rsp_valid && !rsp_tag && !rsp_ld_fault);

  assert_fault_zero_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_ld_fault || rsp_st_fault) |-> !rsp_tag);

  assert_upd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && !upd_ready |=> upd_valid && $stable(upd_crg));

  assert_upd_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> upd_cw && !req_ready);

  assert_upd_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && upd_ready |=> rsp_valid && !upd_valid && !rsp_ld_fault && !rsp_st_fault);

  assert_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (!req_is_cap || !xlate_on) && no_perm && req_kind == 2'b01
    |=> rsp_valid && !rsp_ld_fault && !rsp_st_fault && !upd_valid && rsp_tag == $past(mem_tag));

  assert_perm_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc && perm_fault_ld |=> rsp_valid && rsp_ld_fault && !upd_valid);

  assert_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid || upd_valid);

  assert_rsp_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(acc) || $past(upd_valid && upd_ready));

endmodule

bind cap_page_guard cap_page_guard_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_kind      (req_kind),
  .req_is_cap    (req_is_cap),
  .xlate_on      (xlate_on),
  .pte_cw        (pte_cw),
  .mem_tag       (mem_tag),
  .perm_fault_ld (perm_fault_ld),
  .perm_fault_st (perm_fault_st),
  .rsp_valid     (rsp_valid),
  .rsp_tag       (rsp_tag),
  .rsp_ld_fault  (rsp_ld_fault),
  .rsp_st_fault  (rsp_st_fault),
  .upd_valid     (upd_valid),
  .upd_ready     (upd_ready),
  .upd_cw        (upd_cw),
  .upd_crg       (upd_crg)
);

// File: tb/sim_cap_page_guard.sv
`timescale 1ns/1ps
module sim_cap_page_guard;

  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            req_valid, req_ready;
  logic [1:0]      req_kind;
  logic            req_is_cap, xlate_on, priv_user, virt_on;
  logic [XLEN-1:0] sts_word, vsts_word;
  logic            pte_cw, pte_crg, mem_tag, wr_tag, wr_tag_clr;
  logic            perm_fault_ld, perm_fault_st, cfg_tag_sensitive, cfg_hw_dirty;
  logic            rsp_valid, rsp_tag, rsp_ld_fault, rsp_st_fault;
  logic            upd_valid, upd_ready, upd_cw, upd_crg;

  int checks   = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  cap_page_guard #(.XLEN(XLEN)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_is_cap(req_is_cap), .xlate_on(xlate_on),
    .priv_user(priv_user), .virt_on(virt_on), .sts_word(sts_word),
    .vsts_word(vsts_word), .pte_cw(pte_cw), .pte_crg(pte_crg),
    .mem_tag(mem_tag), .wr_tag(wr_tag), .wr_tag_clr(wr_tag_clr),
    .perm_fault_ld(perm_fault_ld), .perm_fault_st(perm_fault_st),
    .cfg_tag_sensitive(cfg_tag_sensitive), .cfg_hw_dirty(cfg_hw_dirty),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_ld_fault(rsp_ld_fault),
    .rsp_st_fault(rsp_st_fault), .upd_valid(upd_valid), .upd_ready(upd_ready),
    .upd_cw(upd_cw), .upd_crg(upd_crg)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // status word: generation bits at XLEN-2 (supervisor) and XLEN-3 (user), noise elsewhere
  function automatic logic [XLEN-1:0] mk_sts(input logic sgen, input logic ugen);
    logic [XLEN-1:0] w;
    w = 64'hA000_0000_0000_5A5A;
    w[XLEN-2] = sgen;
    w[XLEN-3] = ugen;
    return w;
  endfunction

  task automatic defaults();
    req_valid = 0; req_kind = 2'b01; req_is_cap = 1; xlate_on = 1;
    priv_user = 0; virt_on = 0; sts_word = mk_sts(0, 0); vsts_word = mk_sts(0, 0);
    pte_cw = 1; pte_crg = 0; mem_tag = 1; wr_tag = 0; wr_tag_clr = 0;
    perm_fault_ld = 0; perm_fault_st = 0; cfg_tag_sensitive = 0; cfg_hw_dirty = 0;
    upd_ready = 0;
  endtask

  // inputs are set at a negedge before calling; result is sampled at the next negedge
  task automatic issue();
    req_valid = 1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  // expect {rsp_valid, tag, ld_fault, st_fault, upd_valid}
  task automatic expect_rsp(input string req, input logic t, input logic lf, input logic sf);
    check(req, {3'b0, rsp_valid, rsp_tag, rsp_ld_fault, rsp_st_fault, upd_valid},
               {3'b0, 1'b1, t, lf, sf, 1'b0});
  endtask

  task automatic t_reset();
    defaults();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R12 reset", {5'b0, rsp_valid, upd_valid, req_ready}, 8'b001);
    rst_n = 1;
    @(negedge clk);
    check("R12 after reset", {5'b0, rsp_valid, upd_valid, req_ready}, 8'b001);
  endtask

  task automatic t_load_cw0();
    for (int m = 0; m < 2; m++) begin
      defaults(); pte_cw = 0; priv_user = m[0]; mem_tag = 1;
      issue();
      expect_rsp("R1 cw0 load strips tag", 0, 0, 0);
    end
  endtask

  task automatic t_gen_match();
    // supervisor: sgen=1, ugen=0, page crg=1 -> match
    defaults(); sts_word = mk_sts(1, 0); pte_crg = 1; priv_user = 0; mem_tag = 1;
    issue(); expect_rsp("R2 S match", 1, 0, 0);
    // user: same status, page crg=1 -> mismatch against ugen=0
    defaults(); sts_word = mk_sts(1, 0); pte_crg = 1; priv_user = 1; mem_tag = 1;
    issue(); expect_rsp("R2 U selects user bit", 0, 1, 0);
    defaults(); sts_word = mk_sts(1, 0); pte_crg = 0; priv_user = 1; mem_tag = 1;
    issue(); expect_rsp("R2 U match", 1, 0, 0);
    defaults(); mem_tag = 0;
    issue(); expect_rsp("R10 match untagged passes 0", 0, 0, 0);
  endtask

  task automatic t_schemes();
    defaults(); pte_crg = 1; mem_tag = 0; cfg_tag_sensitive = 0;
    issue(); expect_rsp("R3 strict untagged faults", 0, 1, 0);
    defaults(); pte_crg = 1; mem_tag = 0; cfg_tag_sensitive = 1;
    issue(); expect_rsp("R3 tag-sensitive untagged ok", 0, 0, 0);
    defaults(); pte_crg = 1; mem_tag = 1; cfg_tag_sensitive = 1;
    issue(); expect_rsp("R3 tag-sensitive tagged faults", 0, 1, 0);
  endtask

  task automatic t_virt();
    defaults(); virt_on = 1; sts_word = mk_sts(0, 0); vsts_word = mk_sts(1, 0); pte_crg = 1;
    issue(); expect_rsp("R4 virt uses vs word", 1, 0, 0);
    defaults(); virt_on = 0; sts_word = mk_sts(0, 0); vsts_word = mk_sts(1, 0); pte_crg = 1;
    issue(); expect_rsp("R4 no virt uses s word", 0, 1, 0);
  endtask

  task automatic t_store_fault();
    defaults(); req_kind = 2'b10; pte_cw = 0; wr_tag = 1; cfg_hw_dirty = 0;
    issue(); expect_rsp("R5 tagged store faults", 0, 0, 1);
    defaults(); req_kind = 2'b10; pte_cw = 1; wr_tag = 1;
    issue(); expect_rsp("R10 store cw1 ok, tag 0", 0, 0, 0);
  endtask

  task automatic t_store_update();
    defaults(); req_kind = 2'b10; pte_cw = 0; wr_tag = 1; cfg_hw_dirty = 1;
    priv_user = 1; sts_word = mk_sts(0, 1);
    issue();
    check("R6 update raised", {4'b0, rsp_valid, upd_valid, upd_cw, upd_crg}, 8'b0111);
    check("R6 stall", {7'b0, req_ready}, 8'd0);
    sts_word = mk_sts(0, 0);
    @(negedge clk);
    check("R6 held", {5'b0, upd_valid, upd_crg, rsp_valid}, 8'b110);
    upd_ready = 1;
    @(negedge clk);
    upd_ready = 0;
    expect_rsp("R6 response after ack", 0, 0, 0);
    check("R6 ready again", {7'b0, req_ready}, 8'd1);
    @(negedge clk);
    check("R10 single response", {7'b0, rsp_valid}, 8'd0);
  endtask

  task automatic t_cleared_tag();
    defaults(); req_kind = 2'b10; pte_cw = 0; wr_tag = 1; wr_tag_clr = 1; cfg_hw_dirty = 0;
    issue(); expect_rsp("R7 cleared tag no fault", 0, 0, 0);
    defaults(); req_kind = 2'b10; pte_cw = 0; wr_tag = 1; wr_tag_clr = 1; cfg_hw_dirty = 1;
    issue(); expect_rsp("R7 cleared tag no update", 0, 0, 0);
  endtask

  task automatic t_bypass();
    defaults(); req_is_cap = 0; pte_cw = 0; mem_tag = 1;
    issue(); expect_rsp("R8 non-cap load keeps tag", 1, 0, 0);
    defaults(); xlate_on = 0; pte_crg = 1; mem_tag = 1;
    issue(); expect_rsp("R8 no translation keeps tag", 1, 0, 0);
    defaults(); req_is_cap = 0; req_kind = 2'b10; pte_cw = 0; wr_tag = 1;
    issue(); expect_rsp("R8 non-cap store no fault", 0, 0, 0);
    defaults(); req_kind = 2'b00; pte_cw = 0; wr_tag = 1; pte_crg = 1;
    issue(); expect_rsp("R8 kind none", 0, 0, 0);
  endtask

  task automatic t_perm();
    defaults(); perm_fault_ld = 1; mem_tag = 1;
    issue(); expect_rsp("R9 perm load fault", 0, 1, 0);
    defaults(); req_kind = 2'b10; pte_cw = 0; wr_tag = 1; cfg_hw_dirty = 1; perm_fault_st = 1;
    issue(); expect_rsp("R9 perm store blocks update", 0, 0, 1);
    defaults(); req_kind = 2'b01; pte_crg = 1; perm_fault_st = 1;
    issue(); expect_rsp("R9 perm replaces cap fault", 0, 0, 1);
  endtask

  task automatic t_amo();
    defaults(); req_kind = 2'b11; pte_cw = 0; mem_tag = 1; wr_tag = 1; cfg_hw_dirty = 0;
    issue(); expect_rsp("R11 amo cw0 store fault", 0, 0, 1);
    defaults(); req_kind = 2'b11; pte_cw = 1; pte_crg = 1; mem_tag = 1; wr_tag = 1;
    issue(); expect_rsp("R11 amo gen mismatch", 0, 1, 0);
    defaults(); req_kind = 2'b11; pte_cw = 1; mem_tag = 1; wr_tag = 1;
    issue(); expect_rsp("R11 amo all zero gens pass", 1, 0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    defaults();
    rst_n = 0;
    @(negedge clk);
    t_reset();
    t_load_cw0();
    t_gen_match();
    t_schemes();
    t_virt();
    t_store_fault();
    t_store_update();
    t_cleared_tag();
    t_bypass();
    t_perm();
    t_amo();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule